// File: doc/BRIEF.md
# SMBus Target Interface with Bus-Error Recovery

This block is the bus-facing side of a power-supply management controller. It watches the SMBus clock and data lines, which arrive as open-drain inputs. It answers at one fixed 7-bit device address. It can only pull SDA low or release it. Bytes written by a host are passed to a register file, one valid pulse per byte. A flag marks the first byte after the address, which is the command code. For reads, the block takes a byte from the register side each time a new byte starts and shifts it out MSB first.

The block is built to survive a badly behaved bus. Both lines pass through a two-flop synchroniser and a glitch filter, so runt pulses never reach the frame logic. A START or STOP is recognised at any bit. If SCL stays low longer than a programmable limit, the frame is abandoned and SDA is released. A command code above the supported range is NACKed. Both of these errors set a sticky communication-error flag, which the register side clears with a strobe.

The block never stretches the clock. Its SCL drive output stays released at all times.

Top module: `smb_target`

## Requirements
- R1: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks has no effect on framing, data or acknowledgement.
- R2: After a START, the first 8 bits are taken MSB first as a 7-bit address followed by a direction bit (1 = read). A match with DEV_ADDR is acknowledged by pulling SDA low through the ninth clock. Any other address gets no acknowledge, and the rest of that frame is ignored.
- R3: Each written byte is presented on wr_data_o with a single-cycle wr_valid_o pulse. wr_is_cmd_o is 1 for the first byte after a write address and 0 for the bytes that follow. Supported bytes are acknowledged.
- R4: A command byte with a code above SUP_CMD_MAX is not acknowledged and sets cml_err_o. Later bytes of that frame are ignored. A code equal to SUP_CMD_MAX is accepted.
- R5: cml_err_o stays at 1 until a clr_fault_i strobe clears it. A new error in the same cycle as the strobe wins.
- R6: In a read, a byte is taken from rd_data_i as each byte begins, with a one-cycle rd_take_o pulse, and is shifted out MSB first. Another byte follows after a host ACK. A host NACK ends the transfer.
- R7: When filtered SCL stays low for TMO_CYCLES consecutive clocks, the transaction is abandoned, SDA is released and cml_err_o is set.
- R8: After a timeout abort, the next START addressing the device is acknowledged without any reset.
- R9: A START at any bit position restarts address reception. The first written byte after it is again treated as a command.
- R10: A STOP at any bit position releases SDA and returns the block to idle. Clock pulses without a new START are then ignored.
- R11: scl_drive_low_o is never asserted. The block does not stretch the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low_o | output | 1 | Pull SCL low when 1 (never used) |
| sda_drive_low_o | output | 1 | Pull SDA low when 1, release when 0 |
| wr_valid_o | output | 1 | One-cycle strobe for a written byte |
| wr_is_cmd_o | output | 1 | Written byte is the command code |
| wr_data_o | output | 8 | Written byte value |
| rd_take_o | output | 1 | One-cycle strobe: rd_data_i was taken for transmission |
| rd_data_i | input | 8 | Byte to send on the next read byte |
| cml_err_o | output | 1 | Sticky communication-error flag |
| clr_fault_i | input | 1 | Clears cml_err_o |

## Verification
Several properties are checked on every cycle:
- SCL is never driven.
- SDA starts being pulled low only while filtered SCL is low.
- The error flag holds until the strobe, and a clear that meets no new error takes effect.
- A timeout releases SDA and raises the flag.
- A filtered STOP releases SDA.
- A rejected command leaves SDA released.
- Write strobes last one cycle.

Address matching, command tagging, read byte order, host ACK and NACK handling, restart and stop in mid-byte, recovery after a timeout, and rejection of runt pulses depend on whole bit sequences. Only the bench scenarios, which drive a modelled wired-AND bus, can show these.

// File: rtl/smb_target_pkg.sv
package smb_target_pkg;

   localparam int unsigned SMB_BITS = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK,
      ST_SKIP
   } smb_state_e;

   function automatic int unsigned cnt_w(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
   parameter int unsigned FILT_CYCLES = 4,
   parameter bit          MAJORITY    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   import smb_target_pkg::*;

   logic [1:0] sync_q;
   logic       samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], raw_i};
   end
   assign samp = sync_q[1];

   generate
      if (!MAJORITY) begin : g_count
         localparam int unsigned CW = cnt_w(FILT_CYCLES);
         logic [CW-1:0] run_q;
         logic          out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               out_q <= 1'b1;
            end else if (samp == out_q) begin
               run_q <= '0;
            end else if (run_q == CW'(FILT_CYCLES - 1)) begin
               run_q <= '0;
               out_q <= samp;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign clean_o = out_q;
      end else begin : g_vote
         logic [2:0] win_q;
         logic       out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q <= 3'b111;
               out_q <= 1'b1;
            end else begin
               win_q <= {win_q[1:0], samp};
               out_q <= (win_q[0] & win_q[1]) | (win_q[1] & win_q[2]) |
                        (win_q[0] & win_q[2]);
            end
         end
         assign clean_o = out_q;
      end
   endgenerate

endmodule

// File: rtl/smb_low_timer.sv
module smb_low_timer #(
   parameter int unsigned TMO_CYCLES = 425000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   output logic expire_o
);
   import smb_target_pkg::*;

   localparam int unsigned CW = cnt_w(TMO_CYCLES);

   logic [CW-1:0] low_q;
   logic          exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= !scl_i && (low_q == CW'(TMO_CYCLES - 1));
         if (scl_i)                        low_q <= '0;
         else if (low_q != CW'(TMO_CYCLES)) low_q <= low_q + 1'b1;
      end
   end

   assign expire_o = exp_q;

endmodule

// File: rtl/smb_frame_engine.sv
module smb_frame_engine #(
   parameter logic [6:0] DEV_ADDR    = 7'h58,
   parameter logic [7:0] SUP_CMD_MAX = 8'h9F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       abort_i,
   input  logic [7:0] rd_data_i,
   output logic       sda_low_o,
   output logic       wr_valid_o,
   output logic       wr_is_cmd_o,
   output logic [7:0] wr_data_o,
   output logic       rd_take_o,
   output logic       reject_o
);
   import smb_target_pkg::*;

   localparam logic [3:0] LAST_BIT = 4'(SMB_BITS);

   smb_state_e state_q;
   logic       scl_q, sda_q;
   logic [3:0] bits_q;
   logic [7:0] shreg_q, txreg_q, wdata_q;
   logic       in_addr_q, first_q, rw_q, more_q, ack_low_q;
   logic       wvalid_q, wcmd_q, take_q, reject_q;
   logic       scl_rise, scl_fall, start_det, stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bits_q    <= '0;
         shreg_q   <= '0;
         txreg_q   <= '0;
         wdata_q   <= '0;
         in_addr_q <= 1'b0;
         first_q   <= 1'b0;
         rw_q      <= 1'b0;
         more_q    <= 1'b0;
         ack_low_q <= 1'b0;
         wvalid_q  <= 1'b0;
         wcmd_q    <= 1'b0;
         take_q    <= 1'b0;
         reject_q  <= 1'b0;
      end else begin
         wvalid_q <= 1'b0;
         take_q   <= 1'b0;
         reject_q <= 1'b0;
         if (abort_i) begin
            state_q   <= ST_IDLE;
            ack_low_q <= 1'b0;
         end else if (start_det) begin
            state_q   <= ST_RX;
            bits_q    <= '0;
            in_addr_q <= 1'b1;
            first_q   <= 1'b1;
            ack_low_q <= 1'b0;
         end else if (stop_det) begin
            state_q   <= ST_IDLE;
            ack_low_q <= 1'b0;
         end else begin
            case (state_q)
               ST_RX: begin
                  if (scl_rise && bits_q != LAST_BIT) begin
                     shreg_q <= {shreg_q[6:0], sda_i};
                     bits_q  <= bits_q + 1'b1;
                  end else if (scl_fall && bits_q == LAST_BIT) begin
                     bits_q <= '0;
                     if (in_addr_q) begin
                        if (shreg_q[7:1] == DEV_ADDR) begin
                           rw_q      <= shreg_q[0];
                           ack_low_q <= 1'b1;
                           state_q   <= ST_ACK;
                        end else begin
                           state_q <= ST_SKIP;
                        end
                     end else begin
                        wvalid_q <= 1'b1;
                        wdata_q  <= shreg_q;
                        wcmd_q   <= first_q;
                        first_q  <= 1'b0;
                        if (first_q && shreg_q > SUP_CMD_MAX) begin
                           reject_q <= 1'b1;
                           state_q  <= ST_SKIP;
                        end else begin
                           ack_low_q <= 1'b1;
                           state_q   <= ST_ACK;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     ack_low_q <= 1'b0;
                     in_addr_q <= 1'b0;
                     bits_q    <= '0;
                     if (rw_q) begin
                        txreg_q <= rd_data_i;
                        take_q  <= 1'b1;
                        state_q <= ST_TX;
                     end else begin
                        state_q <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bits_q <= bits_q + 1'b1;
                  end else if (scl_fall) begin
                     if (bits_q == LAST_BIT) state_q <= ST_TXACK;
                     else                    txreg_q <= {txreg_q[6:0], 1'b1};
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     more_q <= ~sda_i;
                  end else if (scl_fall) begin
                     if (more_q) begin
                        txreg_q <= rd_data_i;
                        take_q  <= 1'b1;
                        bits_q  <= '0;
                        state_q <= ST_TX;
                     end else begin
                        state_q <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_low_o   = (state_q == ST_TX) ? ~txreg_q[7] : ack_low_q;
   assign wr_valid_o  = wvalid_q;
   assign wr_is_cmd_o = wcmd_q;
   assign wr_data_o   = wdata_q;
   assign rd_take_o   = take_q;
   assign reject_o    = reject_q;

endmodule

// File: rtl/smb_target.sv
module smb_target #(
   parameter logic [6:0]  DEV_ADDR      = 7'h58,
   parameter logic [7:0]  SUP_CMD_MAX   = 8'h9F,
   parameter int unsigned FILT_CYCLES   = 4,
   parameter bit          FILT_MAJORITY = 1'b0,
   parameter int unsigned TMO_CYCLES    = 425000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_drive_low_o,
   output logic       sda_drive_low_o,
   output logic       wr_valid_o,
   output logic       wr_is_cmd_o,
   output logic [7:0] wr_data_o,
   output logic       rd_take_o,
   input  logic [7:0] rd_data_i,
   output logic       cml_err_o,
   input  logic       clr_fault_i
);

   localparam int unsigned N_LINES = 2;

   generate
      if (FILT_CYCLES < 1 || FILT_CYCLES > 1024) begin : g_bad_filt
         $error("smb_target: FILT_CYCLES out of range");
      end
      if (TMO_CYCLES <= 8 * FILT_CYCLES) begin : g_bad_tmo
         $error("smb_target: TMO_CYCLES too small against FILT_CYCLES");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines, clean_lines;
   logic scl_clean, sda_clean, tmo_expire, cmd_reject, cml_q;

   assign raw_lines = {scl_i, sda_i};

   generate
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
         smb_glitch_filter #(
            .FILT_CYCLES(FILT_CYCLES),
            .MAJORITY   (FILT_MAJORITY)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[i]),
            .clean_o(clean_lines[i])
         );
      end
   endgenerate

   assign scl_clean = clean_lines[1];
   assign sda_clean = clean_lines[0];

   smb_low_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_clean),
      .expire_o(tmo_expire)
   );

   smb_frame_engine #(
      .DEV_ADDR   (DEV_ADDR),
      .SUP_CMD_MAX(SUP_CMD_MAX)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_clean),
      .sda_i      (sda_clean),
      .abort_i    (tmo_expire),
      .rd_data_i  (rd_data_i),
      .sda_low_o  (sda_drive_low_o),
      .wr_valid_o (wr_valid_o),
      .wr_is_cmd_o(wr_is_cmd_o),
      .wr_data_o  (wr_data_o),
      .rd_take_o  (rd_take_o),
      .reject_o   (cmd_reject)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cml_q <= 1'b0;
      else if (tmo_expire || cmd_reject)  cml_q <= 1'b1;
      else if (clr_fault_i)               cml_q <= 1'b0;
   end

   assign cml_err_o       = cml_q;
   assign scl_drive_low_o = 1'b0;

endmodule

// File: rtl/smb_target_chk.sv
module smb_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_f,
   input logic sda_f,
   input logic scl_low,
   input logic sda_low,
   input logic cml,
   input logic clr,
   input logic expire,
   input logic reject,
   input logic wr_valid
);

   p_scl_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_low);

   p_drive_in_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low) |-> !scl_f);

   p_abort_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !sda_low);

   p_abort_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> cml);

   p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cml && !clr) |=> cml);

   p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !expire && !reject) |=> !cml);

   p_reject_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> (cml && !sda_low));

   p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_f && $past(scl_f) && !$past(sda_f) && sda_f) |=> !sda_low);

   p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

endmodule

bind smb_target smb_target_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_f   (scl_clean),
   .sda_f   (sda_clean),
   .scl_low (scl_drive_low_o),
   .sda_low (sda_drive_low_o),
   .cml     (cml_err_o),
   .clr     (clr_fault_i),
   .expire  (tmo_expire),
   .reject  (cmd_reject),
   .wr_valid(wr_valid_o)
);

// File: tb/smb_target_tb_top.sv
module smb_target_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 12;
   localparam int FILT       = 3;
   localparam int TMO        = 400;
   localparam logic [6:0] ADDR = 7'h2C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, clr = 1'b0;
   logic scl_drv, sda_drv, wr_valid, wr_cmd, rd_take, cml;
   logic [7:0] wr_data, rd_data;
   logic scl_line, sda_line;

   int n_checks = 0, n_bad = 0;
   int wr_cnt = 0, take_cnt = 0;
   logic [7:0] last_data = '0;
   logic last_cmd = 1'b0, scl_drv_seen = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign scl_line = scl_m & ~scl_drv;
   assign sda_line = sda_m & ~sda_drv;
   assign rd_data  = 8'hA5 + take_cnt[7:0];

   smb_target #(
      .DEV_ADDR(ADDR), .SUP_CMD_MAX(8'h9F), .FILT_CYCLES(FILT),
      .FILT_MAJORITY(1'b0), .TMO_CYCLES(TMO)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_drive_low_o(scl_drv), .sda_drive_low_o(sda_drv),
      .wr_valid_o(wr_valid), .wr_is_cmd_o(wr_cmd), .wr_data_o(wr_data),
      .rd_take_o(rd_take), .rd_data_i(rd_data), .cml_err_o(cml),
      .clr_fault_i(clr)
   );

   always @(posedge clk) begin
      if (rst_n && wr_valid) begin
         wr_cnt    <= wr_cnt + 1;
         last_data <= wr_data;
         last_cmd  <= wr_cmd;
      end
      if (rst_n && rd_take) take_cnt <= take_cnt + 1;
      if (rst_n && scl_drv) scl_drv_seen <= 1'b1;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; idle(HALF);
      scl_m = 1'b1; idle(HALF);
      sda_m = 1'b0; idle(HALF);
      scl_m = 1'b0; idle(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; idle(HALF);
      scl_m = 1'b1; idle(HALF);
      sda_m = 1'b1; idle(HALF);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    idle(HALF);
      scl_m = 1'b1; idle(HALF);
      scl_m = 1'b0; idle(2);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; idle(HALF);
      b = sda_line;
      scl_m = 1'b1; idle(HALF);
      scl_m = 1'b0; idle(2);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      acked = ~a;
   endtask

   task automatic recv_byte(input logic host_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~host_ack);
   endtask

   task automatic pulse_clear();
      clr = 1'b1; idle(1);
      clr = 1'b0; idle(2);
   endtask

   task automatic t_reset();
      check("R11", "reset scl drive", scl_drv, 0);
      check("R2", "reset sda drive", sda_drv, 0);
      check("R5", "reset cml", cml, 0);
      check("R3", "reset write count", wr_cnt, 0);
   endtask

   task automatic t_write();
      logic ak;
      int base = wr_cnt;
      bus_start();
      send_byte({ADDR, 1'b0}, ak);  check("R2", "own address ack", ak, 1);
      send_byte(8'h21, ak);         check("R3", "command ack", ak, 1);
      check("R3", "command flag", last_cmd, 1);
      check("R3", "command data", last_data, 8'h21);
      send_byte(8'h5A, ak);         check("R3", "data ack", ak, 1);
      check("R3", "data flag", last_cmd, 0);
      check("R3", "data value", last_data, 8'h5A);
      check("R3", "write count", wr_cnt, base + 2);
      bus_stop();
      check("R4", "no error on good write", cml, 0);
   endtask

   task automatic t_wrong_addr();
      logic ak;
      int base = wr_cnt;
      bus_start();
      send_byte({ADDR ^ 7'h01, 1'b0}, ak); check("R2", "foreign address nack", ak, 0);
      send_byte(8'h11, ak);                check("R2", "foreign data nack", ak, 0);
      check("R2", "foreign frame no write", wr_cnt, base);
      bus_stop();
   endtask

   task automatic t_unsupported();
      logic ak;
      int base;
      bus_start();
      send_byte({ADDR, 1'b0}, ak);
      send_byte(8'h9F, ak);   check("R4", "top supported code ack", ak, 1);
      check("R4", "top supported code no error", cml, 0);
      bus_stop();
      bus_start();
      send_byte({ADDR, 1'b0}, ak);
      send_byte(8'hA0, ak);   check("R4", "unsupported code nack", ak, 0);
      check("R4", "unsupported code flag", cml, 1);
      base = wr_cnt;
      send_byte(8'h33, ak);   check("R4", "byte after reject nack", ak, 0);
      check("R4", "byte after reject dropped", wr_cnt, base);
      bus_stop();
      idle(50);
      check("R5", "flag sticky", cml, 1);
      pulse_clear();
      check("R5", "flag cleared", cml, 0);
   endtask

   task automatic t_read();
      logic ak;
      logic [7:0] v;
      int base = take_cnt;
      bus_start();
      send_byte({ADDR, 1'b1}, ak); check("R2", "read address ack", ak, 1);
      recv_byte(1'b1, v);          check("R6", "first read byte", v, 8'hA5 + base);
      recv_byte(1'b0, v);          check("R6", "second read byte", v, 8'hA5 + base + 1);
      idle(HALF);
      check("R6", "no fetch after host nack", take_cnt, base + 2);
      check("R6", "sda released after nack", sda_drv, 0);
      bus_stop();
   endtask

   task automatic t_timeout();
      logic ak;
      bus_start();
      for (int i = 7; i >= 0; i--) send_bit(ADDR[i > 0 ? i - 1 : 0] & (i > 0));
      idle(HALF);
      check("R7", "ack held before timeout", sda_drv, 1);
      idle(TMO + 30);
      check("R7", "sda released after timeout", sda_drv, 0);
      check("R7", "timeout sets flag", cml, 1);
      scl_m = 1'b1; idle(HALF);
      bus_start();
      send_byte({ADDR, 1'b0}, ak); check("R8", "ack after recovery", ak, 1);
      bus_stop();
      check("R5", "flag still set after recovery", cml, 1);
      pulse_clear();
   endtask

   task automatic t_restart();
      logic ak;
      int base = wr_cnt;
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      send_byte({ADDR, 1'b0}, ak); check("R9", "ack after mid-address restart", ak, 1);
      check("R9", "no write from partial frame", wr_cnt, base);
      send_byte(8'h10, ak);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      bus_start();
      send_byte({ADDR, 1'b0}, ak); check("R9", "ack after mid-data restart", ak, 1);
      send_byte(8'h12, ak);
      check("R9", "first byte after restart is command", last_cmd, 1);
      check("R9", "command value after restart", last_data, 8'h12);
      bus_stop();
   endtask

   task automatic t_stop_mid();
      logic ak;
      int base;
      bus_start();
      send_byte({ADDR, 1'b0}, ak);
      send_byte(8'h20, ak);
      base = wr_cnt;
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
      bus_stop();
      check("R10", "sda released after stop", sda_drv, 0);
      send_byte({ADDR, 1'b0}, ak);
      check("R10", "clocks without start ignored", ak, 0);
      check("R10", "no write after stop", wr_cnt, base);
      scl_m = 1'b1; idle(HALF);
   endtask

   task automatic send_bit_noisy(input logic b);
      sda_m = b;    idle(4);
      scl_m = 1'b1; idle(FILT - 1);
      scl_m = 1'b0; idle(HALF - 4 - (FILT - 1));
      scl_m = 1'b1; idle(4);
      sda_m = ~b;   idle(FILT - 1);
      sda_m = b;    idle(HALF - 4 - (FILT - 1));
      scl_m = 1'b0; idle(2);
   endtask

   task automatic t_glitch();
      logic a;
      logic ak;
      bus_start();
      for (int i = 7; i >= 0; i--) send_bit_noisy(i > 0 ? ADDR[i - 1] : 1'b0);
      recv_bit(a);
      check("R1", "address ack despite runt pulses", a, 0);
      send_byte(8'h44, ak);
      check("R1", "data after runt pulses", last_data, 8'h44);
      check("R1", "command flag after runt pulses", last_cmd, 1);
      bus_stop();
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(10);
      t_reset();
      t_write();
      t_wrong_addr();
      t_unsupported();
      t_read();
      t_timeout();
      t_restart();
      t_stop_mid();
      t_glitch();
      check("R11", "scl never driven", scl_drv_seen, 0);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule